// File: doc/BRIEF.md
# Byte-Parity Check and Generate Unit

This block handles parity for one 36-bit port of a bidirectional FIFO. The port carries four 9-bit bytes, and the top bit of each byte is its parity bit. On the inbound side, every byte that the current bus width uses is checked against an odd/even sense select. A single active-low flag goes low when any checked byte fails.

On the outbound side, the block keeps the output register for words read from FIFO memory. It also holds the port's mailbox register. When generation is enabled, the top bit of each outgoing byte is replaced by parity that is computed freshly from that byte's lower eight bits. Stored contents are never altered by this.

One set of four parity trees serves both jobs. A mailbox read with generation borrows the trees from the input check. While that read lasts, the error flag is forced inactive.

Top module: `bytepar_unit`

## Requirements
- R1: Byte b occupies bits 9b+8 down to 9b, and bit 9b+8 is that byte's parity bit. Bytes are 0 to 8, 9 to 17, 18 to 26 and 27 to 35.
- R2: With `odd_sel`=1, a byte is in error when its nine bits hold an odd number of zeros.
- R3: With `odd_sel`=0, a byte is in error when its nine bits hold an even number of zeros.
- R4: `perr_n` is combinational and active low. It is 0 when at least one checked byte of `din` is in error, and 1 otherwise.
- R5: `bus_size` sets which bytes are checked: 00 checks all four, 01 checks bytes 0 and 1, 10 checks byte 0 only, and 11 (mailbox) checks all four. An unchecked byte never pulls `perr_n` low.
- R6: On a clock edge with `fifo_load`=1 and `gen_en`=0, the output register takes all 36 bits of `fifo_rd_data` unchanged.
- R7: On a clock edge with `fifo_load`=1 and `gen_en`=1, the output register keeps the low eight bits of each byte. It replaces each top bit with the bit that makes the byte pass the check under the `odd_sel` value sampled at that edge.
- R8: The output register holds its value when `fifo_load`=0. A synchronous reset (`rst_n`=0) clears both the output register and the mailbox to zero.
- R9: A mailbox write (`cs_n`=0, `en`=1, `wr`=1, `bus_size`=11) at a clock edge stores `din` exactly as applied, whatever the value of `gen_en`.
- R10: During a mailbox read (`cs_n`=0, `en`=1, `wr`=0, `bus_size`=11), `dout` shows the mailbox contents, with top bits regenerated as in R7 when `gen_en`=1. With `gen_en`=1, `perr_n` is held at 1 regardless of `din`. Outside a mailbox read, `dout` shows the output register.
- R11: A mailbox read with generation leaves the stored mailbox contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous reset, active low |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| bus_size | input | 2 | Width code / mailbox select (see R5) |
| cs_n | input | 1 | Port chip select, active low |
| en | input | 1 | Port access enable |
| wr | input | 1 | 1 = write, 0 = read |
| gen_en | input | 1 | Parity generation on reads |
| din | input | 36 | Inbound port data |
| fifo_load | input | 1 | Load a new FIFO word into the output register |
| fifo_rd_data | input | 36 | Word read from FIFO memory |
| dout | output | 36 | Outbound port data |
| perr_n | output | 1 | Parity error flag, active low |

## Verification
The input check and the mailbox-read generation compete for the same trees in a single cycle. The bench provokes this by issuing mailbox reads with generation enabled while `din` carries bytes with deliberately bad parity. It then judges that `perr_n` stays high and that `dout` carries regenerated parity. A FIFO load with generation can also coincide with a mailbox read, so the bench checks that the registered word and the mailbox view remain separate. A behavioural model that counts zeros per byte is compared against both outputs on every cycle.

// File: rtl/bytepar_unit.sv
module bytepar_unit #(
  parameter int BYTES = 4,
  parameter int BW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                odd_sel,
  input  logic [1:0]          bus_size,
  input  logic                cs_n,
  input  logic                en,
  input  logic                wr,
  input  logic                gen_en,
  input  logic [BYTES*BW-1:0] din,
  input  logic                fifo_load,
  input  logic [BYTES*BW-1:0] fifo_rd_data,
  output logic [BYTES*BW-1:0] dout,
  output logic                perr_n
);
  localparam int W    = BYTES * BW;
  localparam int HALF = (BYTES / 2 > 0) ? BYTES / 2 : 1;

  logic [W-1:0]     out_q, mbox_q, tree_in, mbox_gen, fifo_gen;
  logic [BYTES-1:0] valid, fail, tree_par;
  logic             access, mb_sel, mb_wr, mb_rd, mb_gen;

  assign access = !cs_n && en;
  assign mb_sel = (bus_size == 2'b11);
  assign mb_wr  = access && wr && mb_sel;
  assign mb_rd  = access && !wr && mb_sel;
  assign mb_gen = mb_rd && gen_en;

  always_comb begin
    valid = '0;
    case (bus_size)
      2'b01:   valid[HALF-1:0] = '1;
      2'b10:   valid[0] = 1'b1;
      default: valid = '1;
    endcase
  end

  assign tree_in = mb_gen ? mbox_q : din;

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    localparam int LO = g * BW;
    localparam int HI = g * BW + BW - 1;

    assign tree_par[g] = ^tree_in[HI-1:LO];
    assign fail[g]     = odd_sel ? ~(tree_par[g] ^ tree_in[HI])
                                 :  (tree_par[g] ^ tree_in[HI]);

    assign mbox_gen[HI-1:LO] = mbox_q[HI-1:LO];
    assign mbox_gen[HI]      = odd_sel ^ tree_par[g];

    assign fifo_gen[HI-1:LO] = fifo_rd_data[HI-1:LO];
    assign fifo_gen[HI]      = odd_sel ^ (^fifo_rd_data[HI-1:LO]);

    a_r7_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_load |=> out_q[HI-1:LO] == $past(fifo_rd_data[HI-1:LO]));
  end

  assign perr_n = mb_gen | ~|(fail & valid);
  assign dout   = mb_rd ? (gen_en ? mbox_gen : mbox_q) : out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      mbox_q <= '0;
    end else begin
      if (fifo_load) out_q <= gen_en ? fifo_gen : fifo_rd_data;
      if (mb_wr)     mbox_q <= din;
    end
  end

  a_r8_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (out_q == '0 && mbox_q == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_load |=> $stable(out_q));

  a_r6_raw_load: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_load && !gen_en) |=> out_q == $past(fifo_rd_data));

  a_r11_mbox_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !mb_wr |=> $stable(mbox_q));

  a_r9_mbox_store: assert property (@(posedge clk) disable iff (!rst_n)
    mb_wr |=> mbox_q == $past(din));

endmodule

// File: tb/bytepar_unit_bench.sv
module bytepar_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n, odd_sel, cs_n, en, wr, gen_en, fifo_load;
  logic [1:0]  bus_size;
  logic [35:0] din, fifo_rd_data, dout;
  logic        perr_n;

  int n_tests = 0;
  int n_fail  = 0;

  logic [35:0] m_out, m_mbox;
  bit          m_loaded, m_last_gen;

  bytepar_unit u_bytepar_unit (
    .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .bus_size(bus_size),
    .cs_n(cs_n), .en(en), .wr(wr), .gen_en(gen_en), .din(din),
    .fifo_load(fifo_load), .fifo_rd_data(fifo_rd_data),
    .dout(dout), .perr_n(perr_n)
  );

  always #4 clk = ~clk;

  function automatic bit byte_bad(input logic [8:0] b, input bit odd);
    int zeros = 9 - $countones(b);
    return odd ? (zeros % 2 == 1) : (zeros % 2 == 0);
  endfunction

  function automatic logic [35:0] regen(input logic [35:0] d, input bit odd);
    logic [35:0] r = d;
    for (int b = 0; b < 4; b++) begin
      logic [8:0] t = {1'b0, d[9*b +: 8]};
      if (byte_bad(t, odd)) t[8] = 1'b1;
      r[9*b +: 9] = t;
    end
    return r;
  endfunction

  function automatic int checked_bytes(input logic [1:0] sz);
    case (sz)
      2'b01:   return 2;
      2'b10:   return 1;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    bit          mrd, mgen, err;
    logic [35:0] exp_d;
    string       tag;
    #1;
    mrd  = !cs_n && en && !wr && bus_size == 2'b11;
    mgen = mrd && gen_en;
    err  = 0;
    for (int b = 0; b < checked_bytes(bus_size); b++)
      if (byte_bad(din[9*b +: 9], odd_sel)) err = 1;
    if (mgen) tag = "R10";
    else if (bus_size != 2'b00) tag = "R5";
    else tag = odd_sel ? "R2" : "R3";
    chk({tag, " perr_n"}, {35'd0, perr_n}, {35'd0, (mgen ? 1'b1 : !err)});
    if (mrd) begin
      exp_d = gen_en ? regen(m_mbox, odd_sel) : m_mbox;
      tag = "R10";
    end else begin
      exp_d = m_out;
      tag = !m_loaded ? "R8" : (m_last_gen ? "R7" : "R6");
    end
    chk({tag, " dout"}, dout, exp_d);
    @(posedge clk);
    if (!rst_n) begin
      m_out = '0; m_mbox = '0; m_loaded = 0;
    end else begin
      if (fifo_load) begin
        m_out = gen_en ? regen(fifo_rd_data, odd_sel) : fifo_rd_data;
        m_loaded = 1; m_last_gen = gen_en;
      end
      if (!cs_n && en && wr && bus_size == 2'b11) m_mbox = din;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cs_n = 1; en = 0; wr = 0; fifo_load = 0; gen_en = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; odd_sel = 1; bus_size = 0; din = '0; fifo_rd_data = '0;
    idle();
    m_out = 'x; m_mbox = 'x; m_loaded = 0; m_last_gen = 0;
    @(negedge clk);
    step(); step();
    rst_n = 1;
    chk("R8 reset dout", dout, 36'h0);

    // R1: all-zero data with odd generation sets exactly bits 8,17,26,35
    fifo_rd_data = 36'h0; fifo_load = 1; gen_en = 1; odd_sel = 1;
    step();
    idle();
    chk("R1 parity positions", dout, 36'h804020100);

    // R4: one bad byte pulls the flag low; R5: masked when outside width
    din = 36'h804020100 ^ 36'h000040000;
    bus_size = 2'b00; #1; chk("R4 one bad byte", {35'd0, perr_n}, 36'd0);
    step();
    bus_size = 2'b01; #1; chk("R5 byte2 masked", {35'd0, perr_n}, 36'd1);
    step();
    din = 36'h804020100;
    bus_size = 2'b00; #1; chk("R4 all good", {35'd0, perr_n}, 36'd1);
    step();

    // R9: mailbox write with generation on keeps stored top bits
    cs_n = 0; en = 1; wr = 1; bus_size = 2'b11; gen_en = 1; din = 36'h9_0F0F_0F0F;
    step();
    // R10/R11: generating read with bad din, then raw read
    wr = 0; gen_en = 1; din = 36'h0_0000_0001; odd_sel = 0;
    fifo_rd_data = 36'h1_2345_6789; fifo_load = 1;
    step();
    fifo_load = 0;
    #1; chk("R10 flag held", {35'd0, perr_n}, 36'd1);
    step();
    gen_en = 0;
    #1; chk("R11 mailbox intact", dout, 36'h9_0F0F_0F0F);
    chk("R9 mailbox stored", dout, 36'h9_0F0F_0F0F);
    step();
    idle();
    step();

    for (int i = 0; i < 3000; i++) begin
      rst_n        = ($urandom_range(0, 199) != 0);
      odd_sel      = $urandom_range(0, 1);
      bus_size     = $urandom_range(0, 3);
      cs_n         = ($urandom_range(0, 3) == 0);
      en           = ($urandom_range(0, 3) != 0);
      wr           = $urandom_range(0, 1);
      gen_en       = $urandom_range(0, 1);
      fifo_load    = $urandom_range(0, 1);
      din          = {$urandom_range(0, 15), $urandom()};
      fifo_rd_data = {$urandom_range(0, 15), $urandom()};
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule